// File: doc/BRIEF.md
# Segmented Address Translator with Ordered Protection Checks

This block turns a logical address made of a segment number and an offset into a physical address. It looks the segment up in a table held in an external memory. The table's starting address and its number of entries come from two register inputs. Each table entry carries a base address, a segment length, a valid bit and three privilege bits: read, write and execute.

A request is checked in a fixed order. The segment number must be in range, the entry must be valid, the offset must fall inside the segment, and the access kind must be allowed. The response reports the first check that failed. If every check passes, the response carries the base plus the offset.

The segment-number check runs before the table is touched, so a request with an out-of-range segment number never reads the table. The block is fully pipelined. It accepts one request per cycle and answers each one exactly two cycles later, with no backpressure. The table memory must return read data on the cycle after the read is issued.

Top module: `seg_xlate`

## Requirements
- R1: A request presented with `req_valid` high in cycle c produces exactly one response, with `resp_valid` high in cycle c+2. Requests may arrive every cycle, and responses come back in request order.
- R2: When `req_seg` is greater than or equal to `tbl_len`, the response fault code is 1. `tbl_rd_en` stays low in the request cycle.
- R3: For an in-range request, `tbl_rd_en` is high in the request cycle and `tbl_addr` equals `tbl_base + req_seg`. With the default widths, the entry returned on `tbl_rd_data` one cycle later is laid out as follows: bit 31 valid, bit 30 read, bit 29 write, bit 28 execute, bits 27:16 limit, bits 15:0 base.
- R4: An in-range entry whose valid bit is 0 gives fault code 2.
- R5: For a valid entry, an offset greater than or equal to the limit gives fault code 3.
- R6: Access codes on `req_acc` are 0 read, 1 write and 2 execute. Each needs its matching privilege bit. Code 3 is never allowed. A missing privilege on an otherwise legal request gives fault code 4.
- R7: Only the first failing check is reported, in this order: range (1), valid (2), limit (3), permission (4).
- R8: A request passing all checks gives fault code 0 and `resp_paddr = base + offset`, taken modulo 2^PA_W.
- R9: After reset, and in any cycle without a response, `resp_valid`, `resp_fault` and `resp_paddr` are zero. Any faulted response has `resp_paddr` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | TA_W | Memory address of table entry 0 |
| tbl_len | input | SEG_W+1 | Number of segments in the table |
| req_valid | input | 1 | Request present this cycle |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_addr | output | TA_W | Table read address |
| tbl_rd_data | input | PA_W+OFF_W+4 | Table entry, one cycle after the read |
| resp_valid | output | 1 | Response present this cycle |
| resp_fault | output | 3 | 0 ok, 1 range, 2 invalid, 3 limit, 4 permission |
| resp_paddr | output | PA_W | Translated physical address, zero on fault |

## Verification
The bench places an invalid entry inside a table that is then shortened. A design that checks validity before range would report fault 2 where fault 1 is due. It also sends an offset exactly equal to the limit, which an off-by-one compare would accept. A request that is both over the limit and lacking permission must report the limit fault, not the permission fault. Out-of-range requests must leave the read strobe low, so a design that reads first and checks afterward is caught at the port. Three back-to-back requests, plus a base near the top of the address space, expose pipeline misalignment and a wrong sum width.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_RANGE   = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PERM    = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;
endpackage

// File: rtl/seg_range_gate.sv
module seg_range_gate #(
    parameter int SEG_W = 4,
    parameter int TA_W  = 8
) (
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [TA_W-1:0]  tbl_base,
    input  logic [SEG_W:0]   tbl_len,
    output logic             oor,
    output logic             rd_en,
    output logic [TA_W-1:0]  rd_addr
);
    // range test precedes and gates the table read
    assign oor     = ({1'b0, req_seg} >= tbl_len);
    assign rd_en   = req_valid && !oor;
    assign rd_addr = tbl_base + TA_W'(req_seg);
endmodule

// File: rtl/seg_entry_check.sv
module seg_entry_check
    import seg_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16,
    localparam int ENT_W = PA_W + OFF_W + 4
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [OFF_W-1:0] off,
    input  acc_e             acc,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr
);
    localparam int LIM_LO = PA_W;
    localparam int X_BIT  = PA_W + OFF_W;
    localparam int W_BIT  = X_BIT + 1;
    localparam int R_BIT  = X_BIT + 2;
    localparam int V_BIT  = X_BIT + 3;

    logic [PA_W-1:0]  base;
    logic [OFF_W-1:0] limit;
    logic             allow;

    assign base  = entry[PA_W-1:0];
    assign limit = entry[LIM_LO +: OFF_W];

    always_comb begin
        unique case (acc)
            ACC_RD:  allow = entry[R_BIT];
            ACC_WR:  allow = entry[W_BIT];
            ACC_EX:  allow = entry[X_BIT];
            default: allow = 1'b0;
        endcase
    end

    always_comb begin
        if (!entry[V_BIT])       fault = FLT_INVALID;
        else if (off >= limit)   fault = FLT_LIMIT;
        else if (!allow)         fault = FLT_PERM;
        else                     fault = FLT_NONE;
    end

    assign paddr = base + PA_W'(off);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16,
    parameter int TA_W  = 8,
    localparam int ENT_W = PA_W + OFF_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TA_W-1:0]  tbl_base,
    input  logic [SEG_W:0]   tbl_len,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_acc,
    output logic             tbl_rd_en,
    output logic [TA_W-1:0]  tbl_addr,
    input  logic [ENT_W-1:0] tbl_rd_data,
    output logic             resp_valid,
    output logic [2:0]       resp_fault,
    output logic [PA_W-1:0]  resp_paddr
);
    typedef struct packed {
        logic             s1_vld;
        logic             s1_oor;
        logic [OFF_W-1:0] s1_off;
        acc_e             s1_acc;
        logic             o_vld;
        fault_e           o_fault;
        logic [PA_W-1:0]  o_paddr;
    } st_t;

    st_t st_d, st_q;

    logic            oor;
    fault_e          chk_fault;
    logic [PA_W-1:0] chk_paddr;

    seg_range_gate #(.SEG_W(SEG_W), .TA_W(TA_W)) u_gate (
        .req_valid (req_valid),
        .req_seg   (req_seg),
        .tbl_base  (tbl_base),
        .tbl_len   (tbl_len),
        .oor       (oor),
        .rd_en     (tbl_rd_en),
        .rd_addr   (tbl_addr)
    );

    seg_entry_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
        .entry (tbl_rd_data),
        .off   (st_q.s1_off),
        .acc   (st_q.s1_acc),
        .fault (chk_fault),
        .paddr (chk_paddr)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = req_valid;
        st_d.s1_oor = oor;
        st_d.s1_off = req_off;
        st_d.s1_acc = acc_e'(req_acc);
        st_d.o_vld  = st_q.s1_vld;
        if (!st_q.s1_vld) begin
            st_d.o_fault = FLT_NONE;
            st_d.o_paddr = '0;
        end else if (st_q.s1_oor) begin
            st_d.o_fault = FLT_RANGE;
            st_d.o_paddr = '0;
        end else begin
            st_d.o_fault = chk_fault;
            st_d.o_paddr = (chk_fault == FLT_NONE) ? chk_paddr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid = st_q.o_vld;
    assign resp_fault = st_q.o_fault;
    assign resp_paddr = st_q.o_paddr;

    // R1: response exactly two cycles after each request
    a_r1_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 resp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> ##2 !resp_valid);
    // R2: out-of-range request yields fault 1 two cycles on
    a_r2_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= tbl_len)) |-> ##2 (resp_fault == 3'd1));
    // R3: table read only on behalf of a request
    a_r3_read_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |-> req_valid);
    // R9: faulted or absent responses carry no address
    a_r9_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_fault != 3'd0) |-> (resp_paddr == '0));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (resp_fault == 3'd0 && resp_paddr == '0));
    // R7: codes stay within the defined set
    a_r7_code_set: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_fault <= 3'd4));
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tbl_base = 8'h10;
    logic [4:0]  tbl_len = 5'd5;
    logic        req_valid = 1'b0;
    logic [3:0]  req_seg = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic        tbl_rd_en;
    logic [7:0]  tbl_addr;
    logic [31:0] tbl_rd_data = '0;
    logic        resp_valid;
    logic [2:0]  resp_fault;
    logic [15:0] resp_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate u0 (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .tbl_rd_en(tbl_rd_en), .tbl_addr(tbl_addr), .tbl_rd_data(tbl_rd_data),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
    );

    always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_addr];

    function automatic logic [31:0] mk(bit v, bit r, bit w, bit x, logic [11:0] lim, logic [15:0] b);
        return {v, r, w, x, lim, b};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one request, checked at the read port and two cycles later
    task automatic xact(string tag, logic [3:0] s, logic [11:0] o, logic [1:0] a,
                        logic [2:0] ef, logic [15:0] ea);
        bit in_rng;
        in_rng = ({1'b0, s} < tbl_len);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
        #1;
        chk({tag, " R2/R3 rd_en"}, tbl_rd_en, in_rng);
        if (in_rng) chk({tag, " R3 addr"}, tbl_addr, tbl_base + s);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R1 not early"}, resp_valid, 0);
        @(negedge clk);
        chk({tag, " R1 valid"}, resp_valid, 1);
        chk({tag, " fault"}, resp_fault, ef);
        chk({tag, " paddr"}, resp_paddr, ea);
    endtask

    task automatic t_reset;
        chk("R9 reset valid", resp_valid, 0);
        chk("R9 reset fault", resp_fault, 0);
        chk("R9 reset paddr", resp_paddr, 0);
        chk("R3 reset rd_en", tbl_rd_en, 0);
    endtask

    task automatic t_ok_and_limit;
        xact("R8 read ok", 4'd2, 12'h0ff, 2'd0, 3'd0, 16'h10ff);
        xact("R5 offset at limit", 4'd2, 12'h100, 2'd0, 3'd3, 16'h0);
        xact("R8 wrap", 4'd4, 12'h020, 2'd0, 3'd0, 16'h0010);
    endtask

    task automatic t_range;
        xact("R2 out of range", 4'd5, 12'h001, 2'd0, 3'd1, 16'h0);
        xact("R2 far out", 4'd15, 12'h000, 2'd2, 3'd1, 16'h0);
    endtask

    task automatic t_invalid;
        xact("R4 R7 invalid beats limit", 4'd3, 12'h500, 2'd3, 3'd2, 16'h0);
        xact("R4 invalid in bounds", 4'd3, 12'h001, 2'd0, 3'd2, 16'h0);
    endtask

    task automatic t_perm;
        xact("R6 write read-only", 4'd2, 12'h010, 2'd1, 3'd4, 16'h0);
        xact("R6 exec allowed", 4'd1, 12'h03f, 2'd2, 3'd0, 16'h303f);
        xact("R6 exec denied", 4'd0, 12'h001, 2'd2, 3'd4, 16'h0);
        xact("R6 reserved code", 4'd4, 12'h001, 2'd3, 3'd4, 16'h0);
        xact("R6 write allowed", 4'd0, 12'h07f, 2'd1, 3'd0, 16'h207f);
        xact("R7 limit beats perm", 4'd1, 12'h040, 2'd1, 3'd3, 16'h0);
    endtask

    task automatic t_priority_range;
        tbl_len = 5'd3;
        xact("R7 range beats invalid", 4'd3, 12'h001, 2'd0, 3'd1, 16'h0);
        tbl_len = 5'd5;
    endtask

    task automatic t_pipe;
        @(negedge clk);
        req_valid = 1'b1; req_seg = 4'd2; req_off = 12'h004; req_acc = 2'd0;
        @(negedge clk);
        req_seg = 4'd5; req_off = 12'h000;
        @(negedge clk);
        req_seg = 4'd1; req_off = 12'h011; req_acc = 2'd2;
        chk("R1 pipe a valid", resp_valid, 1);
        chk("R1 pipe a paddr", resp_paddr, 16'h1004);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 pipe b fault", resp_fault, 3'd1);
        @(negedge clk);
        chk("R1 pipe c paddr", resp_paddr, 16'h3011);
        chk("R1 pipe c fault", resp_fault, 3'd0);
        @(negedge clk);
        chk("R1 pipe drained", resp_valid, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h10] = mk(1, 1, 1, 0, 12'h080, 16'h2000);
        mem[8'h11] = mk(1, 1, 0, 1, 12'h040, 16'h3000);
        mem[8'h12] = mk(1, 1, 0, 0, 12'h100, 16'h1000);
        mem[8'h13] = mk(0, 1, 1, 1, 12'h010, 16'h4000);
        mem[8'h14] = mk(1, 1, 1, 1, 12'h100, 16'hfff0);
        mem[8'h15] = mk(1, 1, 1, 1, 12'hfff, 16'h5000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ok_and_limit;
        t_range;
        t_invalid;
        t_perm;
        t_priority_range;
        t_pipe;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule